// File: doc/BRIEF.md
# Carry-Save Serial Dot-Product Engine

This block forms the signed dot product of four two's-complement samples with four fixed coefficients, and it uses no multiplier. The coefficients are elaboration-time parameters. A start pulse loads all four samples at once. From then on, one bit of each sample per clock, least significant first, selects one of sixteen precomputed coefficient partial sums.

That partial sum is folded into a row of single-bit adder cells. Each cell keeps its own carry and its own sum bit, so no carry ever travels along the row during an iteration. The lowest cell emits one finished product bit per clock into a serial register. On the sign-bit clock the partial sum is bit-inverted so that it is subtracted, but the matching +1 is held back. After the last bit clock, one resolving adder merges the leftover sum and carry vectors, the serial low bits, the held-back one and a fixed bias. The result is registered and announced by a one-cycle done pulse.

The product is `SAMPLE_W + COEF_W + 2` bits wide, which holds the full signed result without overflow.

Top module: `dacs_mac`

## Requirements
- R1: While reset is asserted, and after it is released with no start, `done` is 0 and `product` is 0.
- R2: `product`, read as a signed value, equals COEF0·a + COEF1·b + COEF2·c + COEF3·d. Each sample is a two's-complement `SAMPLE_W`-bit integer and each coefficient is a signed integer that fits in `COEF_W` bits.
- R3: When `start` is sampled high on a rising edge while the engine is idle, `done` is high for exactly one cycle. That cycle follows the (SAMPLE_W+1)-th rising edge after the accepting edge, and `product` holds the new result from that same cycle.
- R4: A `start` that arrives while a computation is in progress is ignored. The running result, its samples and its done timing are unchanged, and no extra done pulse follows.
- R5: The result is exact at the extremes: samples equal to -2^(SAMPLE_W-1) and 2^(SAMPLE_W-1)-1, with the most negative coefficient.
- R6: `product` keeps its value until the next completion overwrites it. It does not change in any cycle where `done` does not rise.
- R7: A `start` applied in the cycle where `done` is high is accepted, and the second result follows with the same latency as in R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load the four samples and begin, when idle |
| samp_a | input | SAMPLE_W | Sample weighted by COEF0 |
| samp_b | input | SAMPLE_W | Sample weighted by COEF1 |
| samp_c | input | SAMPLE_W | Sample weighted by COEF2 |
| samp_d | input | SAMPLE_W | Sample weighted by COEF3 |
| done | output | 1 | One-cycle completion pulse |
| product | output | SAMPLE_W+COEF_W+2 | Signed dot-product result |

## Verification
A stuck or mis-weighted cell carry corrupts the high part of the product. It is visible in the first result after the fault, SAMPLE_W+2 cycles after start. An error in the serial low bits, or a wrong inversion on the sign cycle, shows up only for samples whose affected bit is set. That is why one sample at a time is swept through every value while the others sit at corner patterns. A miscounted iteration moves the done pulse and scales the product by a power of two, so both appear on the same completion.

// File: rtl/dacs_pkg.sv
package dacs_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ITER = 2'd1,
    PH_FIN  = 2'd2
  } dacs_phase_t;

  // Sum of the coefficients whose select bit is set.
  function automatic int partial_sum(input logic [3:0] sel,
                                     input int k0, input int k1,
                                     input int k2, input int k3);
    int acc;
    acc = 0;
    if (sel[0]) acc += k0;
    if (sel[1]) acc += k1;
    if (sel[2]) acc += k2;
    if (sel[3]) acc += k3;
    return acc;
  endfunction

  // Three-input bit adder: returns {carry, sum}.
  function automatic logic [1:0] add3(input logic x, input logic y, input logic z);
    return {(x & y) | (x & z) | (y & z), x ^ y ^ z};
  endfunction

endpackage

// File: rtl/dacs_psc.sv
module dacs_psc #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             shift,
  input  logic [WIDTH-1:0] din,
  output logic             lsb
);
  logic [WIDTH-1:0] sr;

  always_ff @(posedge clk) begin
    if (!rst_n)     sr <= '0;
    else if (load)  sr <= din;
    else if (shift) sr <= {sr[WIDTH-1], sr[WIDTH-1:1]};
  end

  assign lsb = sr[0];

endmodule

// File: rtl/dacs_rom.sv
module dacs_rom #(
  parameter int ZW    = 8,
  parameter int COEF0 = 7,
  parameter int COEF1 = -13,
  parameter int COEF2 = 21,
  parameter int COEF3 = -32
) (
  input  logic [3:0]    sel,
  output logic [ZW-1:0] z
);
  localparam int ENTRIES = 16;

  logic [ZW-1:0] tbl [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    assign tbl[i] = ZW'(dacs_pkg::partial_sum(4'(i), COEF0, COEF1, COEF2, COEF3));
  end

  assign z = tbl[sel];

endmodule

// File: rtl/dacs_pe.sv
module dacs_pe (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic tbit,
  input  logic sin,
  output logic sum_nx,
  output logic sum_q,
  output logic carry_q
);
  logic [1:0] fa;

  assign fa     = dacs_pkg::add3(tbit, sin, carry_q);
  assign sum_nx = fa[0];

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      sum_q   <= 1'b0;
      carry_q <= 1'b0;
    end else if (en) begin
      sum_q   <= fa[0];
      carry_q <= fa[1];
    end
  end

  // R2: every computation starts from an empty cell
  a_r2_cell_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!sum_q && !carry_q));

endmodule

// File: rtl/dacs_mac.sv
module dacs_mac #(
  parameter int SAMPLE_W = 8,
  parameter int COEF_W   = 6,
  parameter int COEF0    = 7,
  parameter int COEF1    = -13,
  parameter int COEF2    = 21,
  parameter int COEF3    = -32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             start,
  input  logic [SAMPLE_W-1:0]              samp_a,
  input  logic [SAMPLE_W-1:0]              samp_b,
  input  logic [SAMPLE_W-1:0]              samp_c,
  input  logic [SAMPLE_W-1:0]              samp_d,
  output logic                             done,
  output logic [SAMPLE_W+COEF_W+1:0]       product
);
  import dacs_pkg::*;

  localparam int ZW   = COEF_W + 2;
  localparam int RW   = SAMPLE_W + ZW;
  localparam int CNTW = (SAMPLE_W > 2) ? $clog2(SAMPLE_W) : 1;
  localparam logic [CNTW-1:0] LAST_CNT = CNTW'(SAMPLE_W - 1);
  localparam logic [ZW-1:0]   MSB_FLIP = ZW'(1) << (ZW - 1);
  localparam logic [RW-1:0]   ONE_RW   = RW'(1);
  // Accumulated offset from flipping the top table bit on every cycle.
  localparam logic [RW-1:0]   BIAS     = ((ONE_RW << SAMPLE_W) - ONE_RW) << (ZW - 1);

  dacs_phase_t     phase;
  logic [CNTW-1:0] cnt;
  logic [SAMPLE_W-1:0] low_sr;

  // named internal events
  logic accept_evt, step_evt, last_evt, fin_evt, inv_evt, emit_bit;

  assign accept_evt = start && (phase == PH_IDLE);
  assign step_evt   = (phase == PH_ITER);
  assign last_evt   = step_evt && (cnt == LAST_CNT);
  assign fin_evt    = (phase == PH_FIN);
  assign inv_evt    = last_evt;

  // parallel-to-serial sample registers
  logic [SAMPLE_W-1:0] samp_arr [4];
  logic [3:0]          bit_sel;

  assign samp_arr[0] = samp_a;
  assign samp_arr[1] = samp_b;
  assign samp_arr[2] = samp_c;
  assign samp_arr[3] = samp_d;

  for (genvar k = 0; k < 4; k++) begin : g_psc
    dacs_psc #(.WIDTH(SAMPLE_W)) u_psc (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (accept_evt),
      .shift (step_evt),
      .din   (samp_arr[k]),
      .lsb   (bit_sel[k])
    );
  end

  // partial-sum table
  logic [ZW-1:0] z_raw, z_feed;

  dacs_rom #(
    .ZW(ZW), .COEF0(COEF0), .COEF1(COEF1), .COEF2(COEF2), .COEF3(COEF3)
  ) u_rom (
    .sel (bit_sel),
    .z   (z_raw)
  );

  assign z_feed = (inv_evt ? ~z_raw : z_raw) ^ MSB_FLIP;

  // carry-save cell row
  logic [ZW-1:0] s_q, c_q, s_nx;
  logic [ZW:0]   s_in;

  assign s_in[ZW] = 1'b0;

  for (genvar j = 0; j < ZW; j++) begin : g_cell
    assign s_in[j] = s_q[j];
    dacs_pe u_pe (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (accept_evt),
      .en      (step_evt),
      .tbit    (z_feed[j]),
      .sin     (s_in[j+1]),
      .sum_nx  (s_nx[j]),
      .sum_q   (s_q[j]),
      .carry_q (c_q[j])
    );
  end

  assign emit_bit = s_nx[0];

  // Merge residual sums, carries, serial low bits, the held-back one and the bias.
  function automatic logic [RW-1:0] resolve(input logic [ZW-1:0] sv,
                                            input logic [ZW-1:0] cv,
                                            input logic [SAMPLE_W-1:0] lo,
                                            input logic io);
    logic [RW-1:0] a_term, c_term, io_term;
    a_term  = {1'b0, sv[ZW-1:1], lo};
    c_term  = {cv, {SAMPLE_W{1'b0}}};
    io_term = RW'(io) << (SAMPLE_W - 1);
    return a_term + c_term + io_term - BIAS;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      low_sr  <= '0;
      done    <= 1'b0;
      product <= '0;
    end else begin
      done <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (accept_evt) begin
            phase <= PH_ITER;
            cnt   <= '0;
          end
        end
        PH_ITER: begin
          low_sr <= {emit_bit, low_sr[SAMPLE_W-1:1]};
          cnt    <= cnt + CNTW'(1);
          if (last_evt) phase <= PH_FIN;
        end
        PH_FIN: begin
          product <= resolve(s_q, c_q, low_sr, 1'b1);
          done    <= 1'b1;
          phase   <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R3: completion is a single-cycle pulse
  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3: done only while the sequencer has returned to idle
  a_r3_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (phase == PH_IDLE));

  // R4: a start while busy never restarts the bit sequence
  a_r4_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && start) |=> !(phase == PH_ITER && cnt == '0));

  // R4: iterations advance one bit per clock until the last
  a_r4_steady_count: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && !last_evt) |=> (phase == PH_ITER && cnt == $past(cnt) + CNTW'(1)));

  // R6: the result changes only on the cycle done rises
  a_r6_product_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(done) |-> $stable(product));

endmodule

// File: tb/dacs_mac_test.sv
module dacs_mac_test;
  localparam int SW = 8;
  localparam int CW = 6;
  localparam int K0 = 7;
  localparam int K1 = -13;
  localparam int K2 = 21;
  localparam int K3 = -32;
  localparam int OW = SW + CW + 2;
  localparam int LAT = SW + 2; // negedge samples from start edge to done

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [SW-1:0] sa = '0, sb = '0, sc = '0, sd = '0;
  logic done;
  logic [OW-1:0] product;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dacs_mac #(.SAMPLE_W(SW), .COEF_W(CW), .COEF0(K0), .COEF1(K1),
             .COEF2(K2), .COEF3(K3)) uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .samp_a(sa), .samp_b(sb), .samp_c(sc), .samp_d(sd),
    .done(done), .product(product)
  );

  function automatic longint expect_dot(input logic [SW-1:0] a, input logic [SW-1:0] b,
                                        input logic [SW-1:0] c, input logic [SW-1:0] d);
    longint r;
    r = longint'($signed(a)) * K0 + longint'($signed(b)) * K1
      + longint'($signed(c)) * K2 + longint'($signed(d)) * K3;
    return r;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_up;
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // launch at a negedge; returns negedge count until done is seen
  task automatic run_op(input logic [SW-1:0] a, input logic [SW-1:0] b,
                        input logic [SW-1:0] c, input logic [SW-1:0] d,
                        input bit poke_busy, output int lat);
    sa = a; sb = b; sc = c; sd = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 60) begin
      if (poke_busy && lat == 3) begin
        sa = ~a; sb = 8'h80; sc = 8'h7f; sd = d ^ 8'h55; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
  endtask

  task automatic op_check(input string req, input logic [SW-1:0] a, input logic [SW-1:0] b,
                          input logic [SW-1:0] c, input logic [SW-1:0] d);
    int lat;
    run_op(a, b, c, d, 1'b0, lat);
    check({req, " latency"}, lat, LAT);
    check({req, " R2 value"}, longint'($signed(product)), expect_dot(a, b, c, d));
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R3 watchdog actual=hung expected=finished");
    finish_up();
  end

  initial begin
    int lat;
    logic [SW-1:0] keep;
    logic [SW-1:0] pat [4];
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 done in reset", done, 0);
    check("R1 product in reset", product, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 done idle", done, 0);
    check("R1 product idle", product, 0);

    // R2 basic patterns
    op_check("R2 zeros", 8'd0, 8'd0, 8'd0, 8'd0);
    op_check("R2 ones", 8'd1, 8'd1, 8'd1, 8'd1);
    op_check("R2 mixed", 8'd3, 8'hfd, 8'd100, 8'hc0);

    // R5 extremes
    op_check("R5 all min", 8'h80, 8'h80, 8'h80, 8'h80);
    op_check("R5 all max", 8'h7f, 8'h7f, 8'h7f, 8'h7f);
    op_check("R5 min on neg coef", 8'h7f, 8'h80, 8'h7f, 8'h80);
    op_check("R5 max on neg coef", 8'h80, 8'h7f, 8'h80, 8'h7f);
    op_check("R5 all minus one", 8'hff, 8'hff, 8'hff, 8'hff);

    // R2 sweep: each sample through every value, others at corner patterns
    pat[0] = 8'h80; pat[1] = 8'h7f; pat[2] = 8'h55; pat[3] = 8'hb3;
    for (int k = 0; k < 4; k++) begin
      for (int v = 0; v < 256; v++) begin
        logic [SW-1:0] x [4];
        for (int q = 0; q < 4; q++) x[q] = pat[(q + k) % 4];
        x[k] = 8'(v);
        op_check("R2 sweep", x[0], x[1], x[2], x[3]);
      end
    end

    // R2 random samples
    for (int i = 0; i < 400; i++) begin
      op_check("R2 random", 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
    end

    // R4: start while busy is ignored
    run_op(8'd17, 8'hee, 8'h80, 8'd90, 1'b1, lat);
    check("R4 latency unchanged", lat, LAT);
    check("R4 value from first samples", longint'($signed(product)),
          expect_dot(8'd17, 8'hee, 8'h80, 8'd90));
    keep = product[SW-1:0];
    begin
      int extra;
      extra = 0;
      for (int i = 0; i < LAT + 4; i++) begin
        @(negedge clk);
        if (done) extra++;
      end
      check("R4 no extra done", extra, 0);
      // R6: result held with no new start
      check("R6 product held", longint'($signed(product)),
            expect_dot(8'd17, 8'hee, 8'h80, 8'd90));
    end

    // R7: back-to-back start in the done cycle
    run_op(8'd5, 8'd6, 8'd7, 8'd8, 1'b0, lat);
    check("R7 first value", longint'($signed(product)), expect_dot(8'd5, 8'd6, 8'd7, 8'd8));
    run_op(8'h81, 8'h22, 8'hf0, 8'h7e, 1'b0, lat);
    check("R7 second latency", lat, LAT);
    check("R7 second value", longint'($signed(product)),
          expect_dot(8'h81, 8'h22, 8'hf0, 8'h7e));
    @(negedge clk);
    check("R3 done one cycle", done, 0);

    finish_up();
  end

endmodule